// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block picks the most urgent of a set of request lines and reports its position as a binary number. Requests, enable and every result are active low. The design is built from eight-request slices. Inside a slice, line 7 wins over all others and line 0 has the lowest priority. Each slice also reports whether any of its lines is active. It passes an enable to the next slice down only when it is enabled and none of its own lines is active.

The top level places `NUM_SLICES` slices in a chain. The slice holding the highest-numbered requests sits first and receives the external enable. Because a slice that is not enabled holds all its outputs high, the per-slice codes can be combined with a plain AND. The group flags of the slices supply the upper code bits and the global valid flag. The enable-out of the last slice lets several of these blocks be chained in turn. The logic is purely combinational.

Top module: `prio_cascade`

## Requirements
- R1: While `enInN` is 1, every output is 1: all bits of `codeN`, `validN` and `enOutN`.
- R2: While `enInN` is 0 and at least one bit of `reqN` is 0, `codeN` is the bitwise inverse of the index of the highest-numbered 0 bit of `reqN`. For example, bit 15 low gives code 4'h0 and only bit 0 low gives code 4'hF.
- R3: While `enInN` is 0, `validN` is 0 exactly when some bit of `reqN` is 0.
- R4: `enOutN` is 0 only when `enInN` is 0 and every bit of `reqN` is 1.
- R5: While `enInN` is 0 and every bit of `reqN` is 1, `codeN` is all ones, `validN` is 1 and `enOutN` is 0.
- R6: Requests of a lower-priority slice have no effect on any output while a higher slice has an active request. At most one slice reports an active group at a time.
- R7: The code bits above bit 2 carry the inverted index of the slice that holds the winning request. Slice k serves `reqN[8k+7:8k]`. Whenever `validN` is 1, `codeN` is all ones.
- R8: The width of `codeN` is 3 + ceil(log2(`NUM_SLICES`)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqN | input | NUM_SLICES*8 | Request lines, active low; a higher index means higher priority |
| enInN | input | 1 | Enable in, active low |
| codeN | output | 3+clog2(NUM_SLICES) | Inverted index of the winning request |
| validN | output | 1 | Low when any request is active while enabled |
| enOutN | output | 1 | Low when enabled and no request is active; drives the next block |

## Verification
The bench builds the block with the default of two slices, which gives sixteen request lines and a four-bit code. At that size the whole input space can be walked: every one of the 65536 request patterns is applied under both enable levels and compared with a behavioural highest-active-bit model. This covers every slice boundary, every case where the upper slice masks the lower one, and the idle and disabled states. A short table of hand-computed vectors and a direct check of the code width come first.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int SLICE_W = 8;
  localparam int IDX_W   = 3;

  // strobes from a slice control to its datapath
  typedef struct packed {
    logic sliceOn;   // enable-in is active
    logic anyReq;    // at least one request line is low
    logic passDown;  // enabled and idle: hand enable to next slice
  } slice_ctl_t;
endpackage

// File: rtl/prio_slice_ctrl.sv
module prio_slice_ctrl
  import prio_pkg::*;
(
  input  logic [SLICE_W-1:0] reqN,
  input  logic               enInN,
  output slice_ctl_t         ctl
);
  always_comb begin
    ctl.sliceOn  = ~enInN;
    ctl.anyReq   = ~(&reqN);
    ctl.passDown = ~enInN & (&reqN);
  end
endmodule

// File: rtl/prio_slice_dp.sv
module prio_slice_dp
  import prio_pkg::*;
(
  input  logic [SLICE_W-1:0] reqN,
  input  slice_ctl_t         ctl,
  output logic [IDX_W-1:0]   codeN
);
  logic [IDX_W-1:0] winIdx;

  // scan upward so the highest low line is the one kept
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < SLICE_W; i++) begin
      if (!reqN[i]) winIdx = i[IDX_W-1:0];
    end
  end

  always_comb begin
    if (ctl.sliceOn && ctl.anyReq) codeN = ~winIdx;
    else                           codeN = '1;
  end

  always_comb begin
    // R2
    idle_code_chk: assert (ctl.anyReq || (codeN == '1))
      else $error("slice code active with no request");
  end
endmodule

// File: rtl/prio_slice.sv
module prio_slice
  import prio_pkg::*;
(
  input  logic [SLICE_W-1:0] reqN,
  input  logic               enInN,
  output logic [IDX_W-1:0]   codeN,
  output logic               gsN,
  output logic               enOutN
);
  slice_ctl_t ctl;

  prio_slice_ctrl u_ctrl (
    .reqN  (reqN),
    .enInN (enInN),
    .ctl   (ctl)
  );

  prio_slice_dp u_dp (
    .reqN  (reqN),
    .ctl   (ctl),
    .codeN (codeN)
  );

  assign gsN    = ~(ctl.sliceOn & ctl.anyReq);
  assign enOutN = ~ctl.passDown;

  always_comb begin
    // R1
    disabled_high_chk: assert (!enInN || (codeN == '1 && gsN && enOutN))
      else $error("disabled slice drives an active output");
    // R3
    group_flag_chk: assert (enInN || (gsN == (&reqN)))
      else $error("group flag disagrees with requests");
    // R4
    pass_down_chk: assert (enOutN || (!enInN && (&reqN)))
      else $error("enable passed down while busy or disabled");
    // R5
    gs_eo_excl_chk: assert (!(gsN == 1'b0 && enOutN == 1'b0))
      else $error("group flag and enable-out both active");
  end
endmodule

// File: rtl/prio_cascade.sv
module prio_cascade
  import prio_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  localparam int REQ_W  = NUM_SLICES * SLICE_W,
  localparam int SEL_W  = $clog2(NUM_SLICES),
  localparam int CODE_W = IDX_W + SEL_W
) (
  input  logic [REQ_W-1:0]  reqN,
  input  logic              enInN,
  output logic [CODE_W-1:0] codeN,
  output logic              validN,
  output logic              enOutN
);
  logic [NUM_SLICES:0]         enChainN;
  logic [NUM_SLICES*IDX_W-1:0] sliceCodeN;
  logic [NUM_SLICES-1:0]       gsN;
  logic [IDX_W-1:0]            lowCodeN;

  assign enChainN[NUM_SLICES] = enInN;

  // slice k serves reqN[8k+7:8k]; enable runs from the top slice down
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    prio_slice u_slice (
      .reqN   (reqN[k*SLICE_W +: SLICE_W]),
      .enInN  (enChainN[k+1]),
      .codeN  (sliceCodeN[k*IDX_W +: IDX_W]),
      .gsN    (gsN[k]),
      .enOutN (enChainN[k])
    );
  end

  // idle or disabled slices hold all ones, so AND merges the codes
  always_comb begin
    lowCodeN = '1;
    for (int k = 0; k < NUM_SLICES; k++) begin
      lowCodeN = lowCodeN & sliceCodeN[k*IDX_W +: IDX_W];
    end
  end

  if (SEL_W > 0) begin : g_upper
    logic [SEL_W-1:0] upperN;
    always_comb begin
      upperN = '1;
      for (int j = 0; j < SEL_W; j++) begin
        for (int k = 0; k < NUM_SLICES; k++) begin
          if (((k >> j) & 1) == 1) upperN[j] = upperN[j] & gsN[k];
        end
      end
    end
    assign codeN = {upperN, lowCodeN};
  end else begin : g_flat
    assign codeN = lowCodeN;
  end

  assign validN = &gsN;
  assign enOutN = enChainN[0];

  always_comb begin
    // R6
    one_group_chk: assert ($countones(~gsN) <= 1)
      else $error("more than one slice claims the group");
    // R7
    idle_code_all_ones_chk: assert (!validN || (codeN == '1))
      else $error("code active without a valid request");
    // R4
    chain_end_chk: assert (enOutN || (!enInN && (&reqN)))
      else $error("final enable-out active while busy");
  end
endmodule

// File: tb/sim_prio_cascade.sv
module sim_prio_cascade;
  localparam int NS  = 2;
  localparam int RW  = NS * 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [RW-1:0] reqN;
  logic          enInN;
  logic [CW-1:0] codeN;
  logic          validN;
  logic          enOutN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  prio_cascade #(.NUM_SLICES(NS)) u0 (
    .reqN   (reqN),
    .enInN  (enInN),
    .codeN  (codeN),
    .validN (validN),
    .enOutN (enOutN)
  );

  // {en, req, code, valid, eo}
  typedef struct packed {
    logic          en;
    logic [RW-1:0] req;
    logic [CW-1:0] code;
    logic          valid;
    logic          eo;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0000, 4'hF, 1'b1, 1'b1},  // R1 disabled, all requests active
    '{1'b0, 16'hFFFF, 4'hF, 1'b1, 1'b0},  // R5 idle
    '{1'b0, 16'h7FFF, 4'h0, 1'b0, 1'b1},  // R2 R7 top line
    '{1'b0, 16'hFFFE, 4'hF, 1'b0, 1'b1},  // R2 R3 lowest line only
    '{1'b0, 16'hFF7F, 4'h8, 1'b0, 1'b1},  // R2 R7 line 7
    '{1'b0, 16'hFEFF, 4'h7, 1'b0, 1'b1},  // R2 R7 line 8
    '{1'b0, 16'h0000, 4'h0, 1'b0, 1'b1},  // R2 all active
    '{1'b0, 16'hEF00, 4'h3, 1'b0, 1'b1},  // R6 lower slice masked
    '{1'b0, 16'hFFEF, 4'hB, 1'b0, 1'b1},  // R2 line 4
    '{1'b0, 16'hDFFB, 4'h2, 1'b0, 1'b1}   // R6 line 13 over line 2
  };

  function automatic logic [CW+1:0] refOut(input logic en, input logic [RW-1:0] r);
    logic [CW-1:0] idx;
    logic          hit;
    idx = '0;
    hit = 1'b0;
    for (int i = 0; i < RW; i++) begin
      if (!r[i]) begin
        idx = i[CW-1:0];
        hit = 1'b1;
      end
    end
    if (en)       return {{CW{1'b1}}, 1'b1, 1'b1};
    else if (hit) return {~idx, 1'b0, 1'b1};
    else          return {{CW{1'b1}}, 1'b1, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [CW+1:0] got, input logic [CW+1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s en=%b req=%h got code/valid/eo=%h/%b/%b expected %h/%b/%b",
               tag, enInN, reqN, got[CW+1:2], got[1], got[0], exp[CW+1:2], exp[1], exp[0]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    enInN = 1'b1;
    reqN  = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // reset-time state: disabled, idle lines (R1)
    check("R1", {codeN, validN, enOutN}, {4'hF, 1'b1, 1'b1});

    // R8 code width
    checks++;
    if ($bits(codeN) != 3 + $clog2(NS)) begin
      fails++;
      $display("FAIL R8 width got %0d expected %0d", $bits(codeN), 3 + $clog2(NS));
    end

    for (int v = 0; v < NV; v++) begin
      enInN = VECS[v].en;
      reqN  = VECS[v].req;
      #2;
      check("R1/R2/R5/R6/R7 table", {codeN, validN, enOutN},
            {VECS[v].code, VECS[v].valid, VECS[v].eo});
    end

    // exhaustive sweep, both enable levels (R2 R3 R4 R6)
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < (1 << RW); p++) begin
        enInN = e[0];
        reqN  = p[RW-1:0];
        #2;
        check("R2/R3/R4/R6 sweep", {codeN, validN, enOutN}, refOut(enInN, reqN));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule